// File: doc/BRIEF.md
# Powered-Device Power-Mode Sequencer

This block is the digital supervisor of a powered device's input power path. It watches two port-voltage comparators, the drain-source comparators of the hot-swap pass switch, a flag telling whether the pass-switch gate is fully on, an over-temperature flag and the power-on-reset and over-voltage flags of the two internal regulators. From these it decides when the pass switch conducts, which of the two current limits (inrush or operational) is in force, when the regulators run, and when the downstream DC-DC converter may start.

The port-voltage decisions are debounced: a turn-on or turn-off level must hold for a programmable number of clock cycles before it takes effect, and the two thresholds form a hysteresis band. Once powered, the block stays in the inrush limit until the output capacitor is charged and the switch has stopped limiting. It then moves to the operational limit, which it keeps until the drain-source voltage rises above the upper power-good level. An over-temperature event shuts everything down. When the event clears with the port still powered, the sequence resumes in the inrush state with the converter held off and soft-start discharged.

Top module: `pd_power_seq`

## Requirements
- R1: After reset the state is off: pass switch, both regulator enables, operational-limit select, converter enable and gate-driver enable are low; the classification-regulator enable and the soft-start discharge command are high.
- R2: From the off state, the sequencer enters inrush only after `port_above_on_i` has been high on FILT_CYCLES consecutive clock edges. The state changes on the edge after the filter expires. A shorter high pulse leaves the state off.
- R3: From any state, the port is declared lost only after `port_above_off_i` has been low on FILT_CYCLES consecutive edges, and the state is off on the following edge. A shorter dip, or `port_above_on_i` falling while `port_above_off_i` stays high, has no effect.
- R4: In inrush, the pass switch and both regulators are enabled, `ilim_oper_o` is 0 (inrush limit), and the converter is off with soft-start discharged.
- R5: Inrush moves to operate on the next edge only when `vds_below_lo_i` and `gate_high_i` are both high in the same cycle; either one alone has no effect. In operate, `ilim_oper_o` is 1.
- R6: Operate is kept while `vds_above_hi_i` is low, even when `vds_below_lo_i` is low. When `vds_above_hi_i` is high, the state returns to inrush on the next edge.
- R7: With the port valid, `over_temp_i` high moves any state to thermal-off on the next edge. Thermal-off disables the pass switch, both regulators and the converter. The classification-regulator enable is low whenever `over_temp_i` is high or the state is thermal-off.
- R8: When `over_temp_i` falls in thermal-off with the port still valid, the next state is inrush, with the converter disabled and soft-start discharged until the R5 handover.
- R9: `conv_en_o` is high only in operate with both `vddh_por_ok_i` and `vddl_por_ok_i` high. `ss_discharge_o` is the inverse of `conv_en_o`.
- R10: `gate_drv_en_o` equals `conv_en_o` gated off while `vddh_ov_i` is high.
- R11: `state_o` encodes off = 0, inrush = 1, operate = 2, thermal-off = 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_above_on_i | input | 1 | Port voltage above turn-on threshold |
| port_above_off_i | input | 1 | Port voltage above turn-off threshold |
| vds_below_lo_i | input | 1 | Pass-switch drain-source below lower power-good level |
| vds_above_hi_i | input | 1 | Pass-switch drain-source above upper power-good level |
| gate_high_i | input | 1 | Pass-switch gate fully on (not limiting) |
| over_temp_i | input | 1 | Over-temperature flag |
| vddh_por_ok_i | input | 1 | High-voltage regulator out of power-on reset |
| vddl_por_ok_i | input | 1 | Low-voltage regulator out of power-on reset |
| vddh_ov_i | input | 1 | High-voltage regulator over-voltage |
| pass_en_o | output | 1 | Pass-switch enable |
| ilim_oper_o | output | 1 | 1 = operational current limit, 0 = inrush limit |
| vddh_en_o | output | 1 | High-voltage regulator enable |
| vddl_en_o | output | 1 | Low-voltage regulator enable |
| class_reg_en_o | output | 1 | Classification regulator enable |
| conv_en_o | output | 1 | DC-DC converter enable |
| ss_discharge_o | output | 1 | Soft-start discharge command |
| gate_drv_en_o | output | 1 | Converter gate-driver enable |
| state_o | output | 2 | Sequencer state |

## Verification
A port-voltage change shows up in the state FILT_CYCLES+1 edges after the first edge that sees it: FILT_CYCLES edges fill the filter and one more moves the state register. Power-good, gate and over-temperature inputs act on the state one edge later. The regulator flags, the over-voltage flag and the over-temperature gating of the classification enable act combinationally. Each stimulus pushes its expected output vector into a queue tagged with the cycle in which it falls due. The monitor compares each entry at the falling edge of exactly that cycle. Dips and pulses one cycle short of the filter are also checked at the cycle they would have taken effect.

// File: rtl/pd_power_seq.sv
module pd_power_seq #(
  parameter int FILT_CYCLES = 9000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       port_above_on_i,
  input  logic       port_above_off_i,
  input  logic       vds_below_lo_i,
  input  logic       vds_above_hi_i,
  input  logic       gate_high_i,
  input  logic       over_temp_i,
  input  logic       vddh_por_ok_i,
  input  logic       vddl_por_ok_i,
  input  logic       vddh_ov_i,
  output logic       pass_en_o,
  output logic       ilim_oper_o,
  output logic       vddh_en_o,
  output logic       vddl_en_o,
  output logic       class_reg_en_o,
  output logic       conv_en_o,
  output logic       ss_discharge_o,
  output logic       gate_drv_en_o,
  output logic [1:0] state_o
);

  localparam int CW = $clog2(FILT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

  typedef enum logic [1:0] {ST_OFF = 2'd0, ST_INRUSH = 2'd1, ST_OPER = 2'd2, ST_THERM = 2'd3} st_t;

  st_t           state_q, state_d;
  logic          port_ok_q;
  logic [CW-1:0] cnt_q;
  logic          toward;

  // filter runs toward the opposite decision of the current one
  assign toward = port_ok_q ? !port_above_off_i : port_above_on_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_ok_q <= 1'b0;
      cnt_q     <= '0;
    end else if (!toward) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      port_ok_q <= !port_ok_q;
      cnt_q     <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    state_d = state_q;
    if (!port_ok_q)       state_d = ST_OFF;
    else if (over_temp_i) state_d = ST_THERM;
    else begin
      unique case (state_q)
        ST_OFF:    state_d = ST_INRUSH;
        ST_THERM:  state_d = ST_INRUSH;
        ST_INRUSH: if (vds_below_lo_i && gate_high_i) state_d = ST_OPER;
        ST_OPER:   if (vds_above_hi_i) state_d = ST_INRUSH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  assign state_o        = state_q;
  assign pass_en_o      = (state_q == ST_INRUSH) || (state_q == ST_OPER);
  assign ilim_oper_o    = (state_q == ST_OPER);
  assign vddh_en_o      = pass_en_o;
  assign vddl_en_o      = pass_en_o;
  assign class_reg_en_o = !over_temp_i && (state_q != ST_THERM);
  assign conv_en_o      = (state_q == ST_OPER) && vddh_por_ok_i && vddl_por_ok_i;
  assign ss_discharge_o = !conv_en_o;
  assign gate_drv_en_o  = conv_en_o && !vddh_ov_i;

  AST_FILT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R2

  AST_UV_TO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !port_ok_q |=> state_q == ST_OFF); // R3

  AST_HANDOVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_INRUSH && port_ok_q && !over_temp_i && vds_below_lo_i && gate_high_i)
      |=> state_q == ST_OPER); // R5

  AST_OPER_ENTRY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OPER && $past(state_q) == ST_INRUSH) |-> $past(vds_below_lo_i && gate_high_i)); // R5

  AST_OPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OPER && port_ok_q && !over_temp_i && !vds_above_hi_i) |=> state_q == ST_OPER); // R6

  AST_OT_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (port_ok_q && over_temp_i) |=> (state_q == ST_THERM && !pass_en_o)); // R7

  AST_THERM_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_THERM && state_q != ST_THERM) |-> (state_q == ST_OFF || state_q == ST_INRUSH)); // R8

endmodule

// File: tb/pd_power_seq_tb.sv
module pd_power_seq_tb;

  localparam int FILT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic on_i = 0, off_i = 0, lo_i = 0, hi_i = 0, gh_i = 0, ot_i = 0;
  logic ph_i = 1, pl_i = 1, ov_i = 0;
  logic pass_en, ilim_oper, vddh_en, vddl_en, class_en, conv_en, ss_dis, gate_en;
  logic [1:0] st;

  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    int          due;
    logic [9:0]  exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pd_power_seq #(.FILT_CYCLES(FILT)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .port_above_on_i(on_i), .port_above_off_i(off_i),
    .vds_below_lo_i(lo_i), .vds_above_hi_i(hi_i), .gate_high_i(gh_i),
    .over_temp_i(ot_i), .vddh_por_ok_i(ph_i), .vddl_por_ok_i(pl_i), .vddh_ov_i(ov_i),
    .pass_en_o(pass_en), .ilim_oper_o(ilim_oper), .vddh_en_o(vddh_en), .vddl_en_o(vddl_en),
    .class_reg_en_o(class_en), .conv_en_o(conv_en), .ss_discharge_o(ss_dis),
    .gate_drv_en_o(gate_en), .state_o(st)
  );

  // expected vector {state, pass, ilim_oper, vddh, vddl, class, conv, ss, gate}
  function automatic logic [9:0] model(input logic [1:0] s);
    logic p, c;
    p = (s == 2'd1) || (s == 2'd2);
    c = (s == 2'd2) && ph_i && pl_i;
    return {s, p, (s == 2'd2), p, p, (!ot_i && s != 2'd3), c, !c, c && !ov_i};
  endfunction

  task automatic expect_in(input int dly, input logic [1:0] s, input string tag);
    item_t it;
    it.due = cyc + dly;
    it.exp = model(s);
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic settle();
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    #2;
    while (q.size() > 0 && q[0].due <= cyc) begin
      logic [9:0] act;
      act = {st, pass_en, ilim_oper, vddh_en, vddl_en, class_en, conv_en, ss_dis, gate_en};
      n_run++;
      if (q[0].due != cyc || act !== q[0].exp) begin
        n_fail++;
        $display("FAIL %s: cycle %0d actual %b expected %b", q[0].tag, cyc, act, q[0].exp);
      end
      void'(q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    expect_in(1, 2'd0, "R1 reset outputs, R11 off encoding");
    settle();

    // R2: pulse one cycle short of the filter
    on_i = 1; off_i = 1;
    expect_in(FILT + 1, 2'd0, "R2 short turn-on pulse ignored");
    step(FILT - 1);
    on_i = 0; off_i = 0;
    settle();
    step(2);

    // R2/R4: full turn-on
    on_i = 1; off_i = 1;
    expect_in(FILT, 2'd0, "R2 still off before filter");
    expect_in(FILT + 1, 2'd1, "R2 R4 inrush after filter, R11 code 1");
    settle();

    // R5: each condition alone
    step(1); lo_i = 1; gh_i = 0;
    expect_in(1, 2'd1, "R5 power-good alone no handover");
    settle();
    lo_i = 0; gh_i = 1;
    expect_in(1, 2'd1, "R5 gate high alone no handover");
    settle();
    lo_i = 1;
    expect_in(1, 2'd2, "R5 R9 both conditions handover, R11 code 2");
    settle();

    // R10 / R9 combinational gating
    ov_i = 1;
    expect_in(1, 2'd2, "R10 over-voltage gates driver");
    settle();
    ov_i = 0; pl_i = 0;
    expect_in(1, 2'd2, "R9 low-regulator reset holds converter");
    settle();
    pl_i = 1; ph_i = 0;
    expect_in(1, 2'd2, "R9 high-regulator reset holds converter");
    settle();
    ph_i = 1;

    // R6 hysteresis
    lo_i = 0; gh_i = 0;
    expect_in(1, 2'd2, "R6 operate kept with power-good low level lost");
    settle();
    hi_i = 1;
    expect_in(1, 2'd1, "R6 upper level releases to inrush");
    settle();
    hi_i = 0; lo_i = 1; gh_i = 1;
    expect_in(1, 2'd2, "R5 second handover");
    settle();

    // R7 / R8
    ot_i = 1;
    expect_in(1, 2'd3, "R7 thermal shutdown, R11 code 3");
    settle();
    lo_i = 0; gh_i = 0;
    ot_i = 0;
    expect_in(1, 2'd1, "R8 restart in inrush with converter off");
    settle();
    step(3);
    expect_in(1, 2'd1, "R8 converter held until power-good");
    settle();
    lo_i = 1; gh_i = 1;
    expect_in(1, 2'd2, "R8 converter released after handover");
    settle();

    // R3: hysteresis and short dip
    on_i = 0;
    expect_in(FILT + 2, 2'd2, "R3 falling below turn-on only has no effect");
    settle();
    off_i = 0;
    expect_in(FILT + 1, 2'd2, "R3 short dip ignored");
    step(FILT - 1);
    off_i = 1;
    settle();
    off_i = 0;
    expect_in(FILT, 2'd2, "R3 still on before filter");
    expect_in(FILT + 1, 2'd0, "R3 port loss returns off");
    settle();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule